// File: doc/BRIEF.md
# Block-Transfer Control Register File

This block sits between a processor bus and a block-storage transfer engine. Software uses it to program two DMA buffer base addresses, a target block address on the card, a block count and a direction. Setting a start bit then launches the transfer. Every card-side quantity counts in 512-byte blocks. The write map and the read map share the same word offsets but hold different registers. Offset 0 takes the transmit buffer address when written and returns the status word when read.

On the read side software sees a status word, the engine's error flags, a count of the blocks still outstanding and the card capacity. The status word holds the synchronised busy flag, the card-presence pin and the memory-initialisation flag. The busy flag from the engine is brought into the bus clock domain through a synchroniser. Its falling edge sets a sticky completion interrupt, which tells software that a transfer or a card initialisation has finished. A read of the status word clears that interrupt.

The bus is word-addressed and has no wait states. A write lands on the clock edge that ends the write cycle. Read data is returned combinationally in the same cycle as the read strobe.

Top module: `xfer_ctl_regs`

## Requirements
- R1: After reset these outputs are all 0: both buffer addresses, the target address, the block count, the direction, the system reset, the start pulse and the interrupt. The remaining count also reads 0.
- R2: A write to word index 0, 1, 3 or 4 updates, in the next cycle, the transmit buffer address, the receive buffer address, the target block address or the block count respectively.
- R3: A write to word index 2 (control) drives the direction output from data bit 31 (0 = write to card, 1 = read from card) and the system reset output from data bit 8. In the same write, data bit 0 = 1 produces a start pulse that is high for exactly the one cycle after the write. Data bit 0 = 0 produces no pulse.
- R4: A read of word index 0 returns the status word. Bit 0 is the synchronised busy flag, bit 1 is the card-detect pin (0 = card present), bit 8 is memory-init done, and all other bits are 0.
- R5: A read of word index 1 returns the 4-bit engine error flags in bits 3:0. Word index 3 returns the card size in blocks. Word indices 4 to 7 read as 0.
- R6: A control write with bit 0 set loads the remaining count (read at word index 2) with the programmed block count. Each block-done pulse after that lowers it by one, and the count stays at 0 once it reaches 0. A control write with bit 0 clear leaves it unchanged.
- R7: A falling edge of the engine busy input sets the interrupt within three cycles. A rising edge does not set it.
- R8: Once set, the interrupt stays high until the status word is read. Reads of any other index leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_idx | input | 3 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| dma_tx_addr | output | 32 | Transmit buffer base address |
| dma_rx_addr | output | 32 | Receive buffer base address |
| eng_tgt_addr | output | 32 | Target start block on the card |
| eng_blk_cnt | output | 32 | Number of blocks to move |
| eng_dir | output | 1 | 0 = write to card, 1 = read from card |
| eng_req | output | 1 | One-cycle start pulse to the engine |
| sys_rst | output | 1 | System reset level to the engine |
| eng_busy | input | 1 | Engine busy flag, asynchronous |
| eng_blk_done | input | 1 | One-cycle pulse per finished block, synchronous |
| eng_err | input | 4 | Engine error flags |
| eng_card_size | input | 32 | Card capacity in blocks |
| card_det_n | input | 1 | Card-detect pin, 0 = present |
| mem_init_done | input | 1 | Buffer memory initialisation complete |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions take two things for granted about the inputs. First, eng_blk_done is synchronous to clk. Second, a start pulse can only follow a control write that carries bit 0 in the previous cycle, so the bus never holds bus_wr for two cycles on the control index. The stimulus keeps to both. Every bus access lasts one cycle and is followed by an idle cycle, and block-done pulses are one cycle wide with gaps between them. The busy input is held for several cycles on each level, so the synchroniser sees clean edges.

// File: rtl/xfer_ctl_pkg.sv
package xfer_ctl_pkg;
    // write-side word indices
    localparam logic [2:0] WIX_TXBUF  = 3'd0;
    localparam logic [2:0] WIX_RXBUF  = 3'd1;
    localparam logic [2:0] WIX_CTRL   = 3'd2;
    localparam logic [2:0] WIX_TARGET = 3'd3;
    localparam logic [2:0] WIX_COUNT  = 3'd4;
    // read-side word indices
    localparam logic [2:0] RIX_STATUS = 3'd0;
    localparam logic [2:0] RIX_ERRORS = 3'd1;
    localparam logic [2:0] RIX_REMAIN = 3'd2;
    localparam logic [2:0] RIX_CSIZE  = 3'd3;
    // control bits
    localparam int CTL_GO_BIT  = 0;
    localparam int CTL_RST_BIT = 8;
    // status bits
    localparam int ST_BUSY_BIT = 0;
    localparam int ST_DET_BIT  = 1;
    localparam int ST_INIT_BIT = 8;
endpackage

// File: rtl/xc_bus_regs.sv
module xc_bus_regs
    import xfer_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tx_addr,
    output logic [DATA_W-1:0] rx_addr,
    output logic [DATA_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] blk_cnt,
    output logic              dir,
    output logic              sys_rst,
    output logic              req
);
    localparam int DIR_BIT = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] tgt;
        logic [DATA_W-1:0] cnt;
        logic              dir;
        logic              rst;
        logic              req;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        if (wr_en) begin
            case (wr_idx)
                WIX_TXBUF:  r_d.tx  = wdata;
                WIX_RXBUF:  r_d.rx  = wdata;
                WIX_TARGET: r_d.tgt = wdata;
                WIX_COUNT:  r_d.cnt = wdata;
                WIX_CTRL: begin
                    r_d.dir = wdata[DIR_BIT];
                    r_d.rst = wdata[CTL_RST_BIT];
                    r_d.req = wdata[CTL_GO_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_addr  = r_q.tx;
    assign rx_addr  = r_q.rx;
    assign tgt_addr = r_q.tgt;
    assign blk_cnt  = r_q.cnt;
    assign dir      = r_q.dir;
    assign sys_rst  = r_q.rst;
    assign req      = r_q.req;

    // R3: a start pulse only ever follows a control write carrying the go bit
    a_r3_req_from_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(wr_en && wr_idx == WIX_CTRL && wdata[CTL_GO_BIT]));

    // R3: the start pulse lasts a single cycle on the one-access-per-cycle bus
    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !(wr_en && wr_idx == WIX_CTRL)) |=> !req);

    // R2: a count write is visible on the next cycle
    a_r2_count_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == WIX_COUNT) |=> blk_cnt == $past(wdata));
endmodule

// File: rtl/xc_remain_cnt.sv
module xc_remain_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (load)
            c_d.cnt = load_val;
        else if (dec && c_q.cnt != '0)
            c_d.cnt = c_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;

    // R6: load takes the programmed count
    a_r6_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R6: one block done lowers the count by exactly one
    a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    // R6: the count never wraps below zero
    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/xc_busy_edge.sv
module xc_busy_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_async,
    input  logic clr,
    output logic busy_s,
    output logic irq
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   irq;
    } edge_t;

    edge_t e_d, e_q;
    logic  fall;

    always_comb begin
        e_d      = e_q;
        e_d.sync = {e_q.sync[SYNC_STAGES-2:0], busy_async};
        e_d.prev = e_q.sync[SYNC_STAGES-1];
        fall     = e_q.prev && !e_q.sync[SYNC_STAGES-1];
        if (fall)     e_d.irq = 1'b1;
        else if (clr) e_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign busy_s = e_q.sync[SYNC_STAGES-1];
    assign irq    = e_q.irq;

    // R8: the interrupt holds until a status read clears it
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);

    // R7: the interrupt only rises after the synchronised busy has fallen
    a_r7_irq_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!busy_s));
endmodule

// File: rtl/xfer_ctl_regs.sv
module xfer_ctl_regs
    import xfer_ctl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ERR_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_idx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] dma_tx_addr,
    output logic [DATA_W-1:0] dma_rx_addr,
    output logic [DATA_W-1:0] eng_tgt_addr,
    output logic [DATA_W-1:0] eng_blk_cnt,
    output logic              eng_dir,
    output logic              eng_req,
    output logic              sys_rst,
    input  logic              eng_busy,
    input  logic              eng_blk_done,
    input  logic [ERR_W-1:0]  eng_err,
    input  logic [DATA_W-1:0] eng_card_size,
    input  logic              card_det_n,
    input  logic              mem_init_done,
    output logic              irq
);
    logic              go_load;
    logic              status_rd;
    logic              busy_s;
    logic [DATA_W-1:0] remain;

    assign go_load   = bus_wr && bus_idx == WIX_CTRL && bus_wdata[CTL_GO_BIT];
    assign status_rd = bus_rd && bus_idx == RIX_STATUS;

    xc_bus_regs #(.DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_idx   (bus_idx),
        .wdata    (bus_wdata),
        .tx_addr  (dma_tx_addr),
        .rx_addr  (dma_rx_addr),
        .tgt_addr (eng_tgt_addr),
        .blk_cnt  (eng_blk_cnt),
        .dir      (eng_dir),
        .sys_rst  (sys_rst),
        .req      (eng_req)
    );

    xc_remain_cnt #(.CNT_W(DATA_W)) remain_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_load),
        .load_val (eng_blk_cnt),
        .dec      (eng_blk_done),
        .cnt      (remain)
    );

    xc_busy_edge #(.SYNC_STAGES(SYNC_STAGES)) busy_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_async (eng_busy),
        .clr        (status_rd),
        .busy_s     (busy_s),
        .irq        (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_idx)
                RIX_STATUS: begin
                    bus_rdata[ST_BUSY_BIT] = busy_s;
                    bus_rdata[ST_DET_BIT]  = card_det_n;
                    bus_rdata[ST_INIT_BIT] = mem_init_done;
                end
                RIX_ERRORS: bus_rdata[ERR_W-1:0] = eng_err;
                RIX_REMAIN: bus_rdata = remain;
                RIX_CSIZE:  bus_rdata = eng_card_size;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R4: status bits outside busy, detect and init always read 0
    a_r4_status_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |-> (bus_rdata & ~((32'd1 << ST_BUSY_BIT) | (32'd1 << ST_DET_BIT)
                                     | (32'd1 << ST_INIT_BIT))) == '0);
endmodule

// File: tb/xfer_ctl_regs_tb.sv
`timescale 1ns/100ps
module xfer_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] dma_tx_addr, dma_rx_addr, eng_tgt_addr, eng_blk_cnt;
    logic        eng_dir, eng_req, sys_rst, irq;
    logic        eng_busy = 1'b0, eng_blk_done = 1'b0;
    logic [3:0]  eng_err = '0;
    logic [31:0] eng_card_size = '0;
    logic        card_det_n = 1'b1, mem_init_done = 1'b0;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    xfer_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_tx_addr(dma_tx_addr), .dma_rx_addr(dma_rx_addr),
        .eng_tgt_addr(eng_tgt_addr), .eng_blk_cnt(eng_blk_cnt),
        .eng_dir(eng_dir), .eng_req(eng_req), .sys_rst(sys_rst),
        .eng_busy(eng_busy), .eng_blk_done(eng_blk_done), .eng_err(eng_err),
        .eng_card_size(eng_card_size), .card_det_n(card_det_n),
        .mem_init_done(mem_init_done), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data while a read is on the bus
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL scoreboard empty actual=0x%08h expected=none", bus_rdata);
                end else begin
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(logic [2:0] idx, logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [2:0] idx, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_idx = idx;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic blk_done_pulse();
        @(posedge clk); #1;
        eng_blk_done = 1'b1;
        @(posedge clk); #1;
        eng_blk_done = 1'b0;
    endtask

    initial begin
        #50000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx", dma_tx_addr, 0);
        check("R1 rx", dma_rx_addr, 0);
        check("R1 tgt", eng_tgt_addr, 0);
        check("R1 cnt", eng_blk_cnt, 0);
        check("R1 dir/rst/req/irq", {28'd0, eng_dir, sys_rst, eng_req, irq}, 0);
        bus_read(3'd2, 32'd0, "R1 remain");

        // R2 write map
        bus_write(3'd0, 32'h9000_0000);
        bus_write(3'd1, 32'h9800_0000);
        bus_write(3'd3, 32'h0000_1234);
        bus_write(3'd4, 32'd3);
        @(negedge clk);
        check("R2 tx", dma_tx_addr, 32'h9000_0000);
        check("R2 rx", dma_rx_addr, 32'h9800_0000);
        check("R2 tgt", eng_tgt_addr, 32'h0000_1234);
        check("R2 cnt", eng_blk_cnt, 32'd3);

        // R4 status layout
        bus_read(3'd0, 32'h0000_0002, "R4 status absent");
        card_det_n = 1'b0; mem_init_done = 1'b1;
        bus_read(3'd0, 32'h0000_0100, "R4 status present+init");

        // R5 other reads
        eng_err = 4'hA; eng_card_size = 32'h00ED_0000;
        bus_read(3'd1, 32'h0000_000A, "R5 errors");
        bus_read(3'd3, 32'h00ED_0000, "R5 card size");
        bus_read(3'd4, 32'd0, "R5 idx4 zero");
        bus_read(3'd7, 32'd0, "R5 idx7 zero");
        check("R2 tx kept after overlay reads", dma_tx_addr, 32'h9000_0000);

        // R3 control with go bit, read direction
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_idx = 3'd2; bus_wdata = 32'h8000_0001;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
        @(negedge clk);
        check("R3 req pulse high", {31'd0, eng_req}, 1);
        check("R3 dir read", {31'd0, eng_dir}, 1);
        @(negedge clk);
        check("R3 req pulse gone", {31'd0, eng_req}, 0);

        // R6 remaining count
        bus_read(3'd2, 32'd3, "R6 loaded");
        blk_done_pulse();
        blk_done_pulse();
        bus_read(3'd2, 32'd1, "R6 after two");
        blk_done_pulse();
        blk_done_pulse();
        blk_done_pulse();
        bus_read(3'd2, 32'd0, "R6 floor");

        // R3 control without go bit: reset level, no pulse, R6 no load
        bus_write(3'd2, 32'h0000_0100);
        @(negedge clk);
        check("R3 no req", {31'd0, eng_req}, 0);
        check("R3 sys_rst", {31'd0, sys_rst}, 1);
        check("R3 dir write", {31'd0, eng_dir}, 0);
        bus_read(3'd2, 32'd0, "R6 no load");
        bus_write(3'd2, 32'h0000_0000);
        @(negedge clk);
        check("R3 sys_rst clear", {31'd0, sys_rst}, 0);

        // R7 rising busy gives no interrupt
        eng_busy = 1'b1;
        idle(5);
        @(negedge clk);
        check("R7 no irq on rise", {31'd0, irq}, 0);
        bus_read(3'd0, 32'h0000_0101, "R4 busy bit");
        // R7 falling busy sets interrupt
        eng_busy = 1'b0;
        idle(4);
        @(negedge clk);
        check("R7 irq on fall", {31'd0, irq}, 1);
        // R8 other reads keep it
        bus_read(3'd1, 32'h0000_000A, "R5 errors again");
        bus_read(3'd3, 32'h00ED_0000, "R5 size again");
        @(negedge clk);
        check("R8 irq kept", {31'd0, irq}, 1);
        bus_read(3'd0, 32'h0000_0100, "R4 status idle");
        @(negedge clk);
        check("R8 irq cleared", {31'd0, irq}, 0);

        idle(2);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule